// File: doc/BRIEF.md
# Heartbeat LED Pattern Generator

This block turns a free-running binary counter into a "heartbeat" indication on a single LED. A plain blinker would toggle the LED from one counter bit and give a steady square wave. This block takes its blink from the bit one position lower, so the blink runs at twice the plain rate. It also adds two more counter bits above the blink bit. The LED may light only while both of those top bits are 1. The result is a short burst of blinking in one quarter of each long period, followed by three quarters of darkness.

The counter comes in two forms, selected by a parameter. The synchronous form is an ordinary incrementing register. The ripple form is a chain of toggle stages built by a generate loop. In that chain only stage 0 runs on the system clock, and each higher stage toggles on the falling edge of the stage below it, so the chain counts upward. In both forms the LED is re-registered on the system clock, which gives a glitch-free pin and a cycle-for-cycle identical pattern. With the default `BLINK_BIT` of 24 and a 100 MHz clock, the counter is 27 bits wide. Its long period is 2^27 cycles, about 1.34 s, and each LED pulse lasts 2^24 cycles.

Top module: `heartbeat_led`

## Requirements
- R1: While `rst` is high at a rising clock edge, every counter bit and `led` are cleared to 0. After that edge `led` reads 0.
- R2: The counter is `BLINK_BIT+3` bits wide. `led` can be 1 only when the two most significant counter bits (indices `BLINK_BIT+2` and `BLINK_BIT+1`) were both 1. This is one quarter of each period of 2^(BLINK_BIT+3) cycles.
- R3: Inside that quarter, `led` follows counter bit `BLINK_BIT`. Each pulse is therefore 2^BLINK_BIT cycles long, and it starts when the bits below `BLINK_BIT` have just wrapped to zero.
- R4: `led` is a register on `clk`. After n rising edges with `rst` low since reset, `led` equals the pattern value of count n-1.
- R5: The counter adds one on every rising edge with `rst` low and wraps modulo 2^(BLINK_BIT+3), so the pattern repeats with that period.
- R6: Setting `IMPL` to the ripple form (each stage toggles on the falling edge of the one below) produces exactly the same `led` sequence as the synchronous form.
- R7: A reset applied while `led` is lit restarts the pattern from count zero. No pulse then appears until 2^(BLINK_BIT+3) - 2^BLINK_BIT + 1 edges after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| led | output | 1 | Heartbeat LED drive, active high |

## Verification
The bench uses `BLINK_BIT` = 2, which makes the counter 5 bits wide and the period 32 cycles. It builds one instance of each counter form and runs both from the same clock and reset. A table of edge counts samples points where only a lower bit or only one top bit is set, which separates a correct two-bit gate from a one-bit gate or a gate on the wrong bits. The table also samples the first and last cycles of the lit burst and the cycles around the counter wrap, to pin down the one-cycle register delay and the blink bit position. A sweep over several periods compares both forms against a model on every cycle. A reset inside the lit burst, followed by a check of the burst edges, shows that the counter was really cleared and not just the LED register.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic {
    HB_SYNC   = 1'b0,
    HB_RIPPLE = 1'b1
  } hb_impl_e;

  typedef struct packed {
    logic clr;    // clear counter and LED
    logic ledOn;  // LED value for the next edge
  } hb_strobe_t;
endpackage

// File: rtl/hbCtrl.sv
module hbCtrl
  import hb_pkg::*;
#(
  parameter int BLINK_BIT = 24,
  localparam int CNT_W = BLINK_BIT + 3
) (
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt,
  output hb_strobe_t       strobe
);
  localparam int TOP_HI = CNT_W - 1;
  localparam int TOP_LO = CNT_W - 2;

  logic inWindow;

  always_comb begin
    inWindow     = cnt[TOP_HI] & cnt[TOP_LO];
    strobe.clr   = rst;
    strobe.ledOn = inWindow & cnt[BLINK_BIT];
  end
endmodule

// File: rtl/hbDatapath.sv
module hbDatapath
  import hb_pkg::*;
#(
  parameter int       BLINK_BIT = 24,
  parameter hb_impl_e IMPL      = HB_SYNC,
  localparam int CNT_W = BLINK_BIT + 3
) (
  input  logic             clk,
  input  hb_strobe_t       strobe,
  output logic [CNT_W-1:0] cnt,
  output logic             led
);
  generate
    if (IMPL == HB_SYNC) begin : g_sync
      logic [CNT_W-1:0] cntQ;
      always_ff @(posedge clk) begin
        if (strobe.clr) cntQ <= '0;
        else            cntQ <= cntQ + 1'b1;
      end
      assign cnt = cntQ;
    end else begin : g_ripple
      logic [CNT_W-1:0] rippleQ;
      logic bit0Q;
      always_ff @(posedge clk) begin
        if (strobe.clr) bit0Q <= 1'b0;
        else            bit0Q <= ~bit0Q;
      end
      assign rippleQ[0] = bit0Q;
      for (genvar k = 1; k < CNT_W; k++) begin : g_stage
        logic stageQ;
        always_ff @(negedge rippleQ[k-1] or posedge strobe.clr) begin
          if (strobe.clr) stageQ <= 1'b0;
          else            stageQ <= ~stageQ;
        end
        assign rippleQ[k] = stageQ;
      end
      assign cnt = rippleQ;
    end
  endgenerate

  // LED re-registered in the system clock domain
  always_ff @(posedge clk) begin
    if (strobe.clr) led <= 1'b0;
    else            led <= strobe.ledOn;
  end

  // R1: first edge after reset release sees cleared state
  a_r1_cleared_after_reset: assert property (@(posedge clk) disable iff (strobe.clr)
    $past(strobe.clr) |-> (led == 1'b0 && cnt == '0));

  // R5: counter steps by one each cycle and wraps
  a_r5_count_step: assert property (@(posedge clk) disable iff (strobe.clr)
    !$past(strobe.clr) |-> (cnt == $past(cnt) + 1'b1));

  // R2: LED lit only if both top bits were set one cycle earlier
  a_r2_led_in_window: assert property (@(posedge clk) disable iff (strobe.clr)
    led |-> ($past(cnt[CNT_W-1]) && $past(cnt[CNT_W-2])));

  // R3: a pulse starts right after the low bits wrapped
  a_r3_pulse_start: assert property (@(posedge clk) disable iff (strobe.clr)
    $rose(led) |-> (cnt[BLINK_BIT:0] == (BLINK_BIT+1)'(1) + (BLINK_BIT+1)'(1 << BLINK_BIT)));
endmodule

// File: rtl/heartbeat_led.sv
module heartbeat_led
  import hb_pkg::*;
#(
  parameter int       BLINK_BIT = 24,
  parameter hb_impl_e IMPL      = HB_SYNC
) (
  input  logic clk,
  input  logic rst,
  output logic led
);
  localparam int CNT_W = BLINK_BIT + 3;

  hb_strobe_t       strobe;
  logic [CNT_W-1:0] cnt;

  hbCtrl #(.BLINK_BIT(BLINK_BIT)) i_ctrl (
    .rst    (rst),
    .cnt    (cnt),
    .strobe (strobe)
  );

  hbDatapath #(.BLINK_BIT(BLINK_BIT), .IMPL(IMPL)) i_dp (
    .clk    (clk),
    .strobe (strobe),
    .cnt    (cnt),
    .led    (led)
  );
endmodule

// File: tb/test_heartbeat_led.sv
module test_heartbeat_led;
  import hb_pkg::*;

  localparam int BB    = 2;
  localparam int CW    = BB + 3;
  localparam int PER   = 1 << CW;
  localparam int NVEC  = 14;
  localparam int LIMIT = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ledSync, ledRip;
  int   checks = 0;
  int   fails  = 0;
  int   n      = 0;

  always #10 clk = ~clk;

  heartbeat_led #(.BLINK_BIT(BB), .IMPL(HB_SYNC)) i_heartbeat_led (
    .clk(clk), .rst(rst), .led(ledSync));
  heartbeat_led #(.BLINK_BIT(BB), .IMPL(HB_RIPPLE)) i_heartbeat_led_ripple (
    .clk(clk), .rst(rst), .led(ledRip));

  // {edges since reset, expected led}; lit when count n-1 is 28..31
  localparam int VEC [NVEC][2] = '{
    '{1, 0}, '{5, 0}, '{13, 0}, '{21, 0}, '{25, 0}, '{28, 0}, '{29, 1},
    '{30, 1}, '{32, 1}, '{33, 0}, '{34, 0}, '{61, 1}, '{64, 1}, '{65, 0}};

  function automatic logic model(int edges);
    int c;
    if (edges == 0) return 1'b0;
    c = (edges - 1) % PER;
    return (c >= PER - (1 << BB)) ? 1'b1 : 1'b0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s n=%0d actual=%b expected=%b", req, n, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    if (!rst) n++;
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(20 * LIMIT);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    step(); step();
    check("R1 sync reset", ledSync, 1'b0);
    check("R1 ripple reset", ledRip, 1'b0);
    rst = 1'b0; n = 0;

    // table walk: R2 gate, R3 blink bit, R4 delay, R5 wrap
    for (int v = 0; v < NVEC; v++) begin
      while (n < VEC[v][0]) step();
      check("R2/R3/R4/R5 table sync", ledSync, 1'(VEC[v][1]));
      check("R6 table ripple", ledRip, 1'(VEC[v][1]));
    end

    // sweep several periods: R5 repeat, R6 equality
    while (n < 4 * PER + 3) begin
      step();
      check("R5 sweep sync", ledSync, model(n));
      check("R6 sweep ripple", ledRip, model(n));
    end

    // reset inside the lit burst
    while (model(n) != 1'b1) step();
    check("R7 lit before reset", ledSync, 1'b1);
    @(posedge clk); #1 rst = 1'b1;
    @(negedge clk);
    step();
    check("R1 led cleared sync", ledSync, 1'b0);
    check("R1 led cleared ripple", ledRip, 1'b0);
    step();
    check("R1 held reset", ledSync | ledRip, 1'b0);
    rst = 1'b0; n = 0;
    while (n < PER - (1 << BB)) begin
      step();
      check("R7 dark after restart", ledSync | ledRip, 1'b0);
    end
    step();
    check("R7 burst start sync", ledSync, 1'b1);
    check("R7 burst start ripple", ledRip, 1'b1);
    finishRun();
  end
endmodule